// File: doc/BRIEF.md
# Y86-64 Instruction Fetch and Length Decoder

This block is the combinational front of a simple Y86-64 processor. It looks at a ten-byte window of instruction memory that starts at the current program counter. From that window it extracts the opcode nibbles, the two register specifiers and the eight-byte constant. It also works out how long the instruction is, from which it produces the next sequential program counter.

The window is presented with the byte at the PC in bits [7:0], the next byte in bits [15:8], and so on. Constants are little-endian. A memory-side flag tells the block whether the fetch address was legal. The block then reports one of four processor status values.

The register file, the ALU, data memory and branch resolution all sit downstream and consume these outputs.

Top module: `y86_fetch_decode`

## Requirements
- R1: `icode` is the high nibble of byte 0 and `ifun` is its low nibble, for every opcode, valid or not.
- R2: Halt (0x0), no-op (0x1) and return (0x9) are one byte long. For these, `ra` and `rb` read 0xF, `valc` is 0 and `valp` is `pc`+1.
- R3: Register moves and conditional moves (0x2), arithmetic (0x6), push (0xA) and pop (0xB) are two bytes long. `ra` is the high nibble of byte 1 and `rb` its low nibble, `valc` is 0 and `valp` is `pc`+2.
- R4: Jumps (0x7) and call (0x8) are nine bytes long. There is no register byte, so `ra`=`rb`=0xF. `valc` is bytes 1..8 read little-endian, and `valp` is `pc`+9.
- R5: Immediate-to-register (0x3), register-to-memory (0x4) and memory-to-register (0x5) moves are ten bytes long. `ra`/`rb` come from byte 1, `valc` is bytes 2..9 read little-endian, and `valp` is `pc`+10.
- R6: `valp` is computed modulo 2^64, so it wraps past the top of the address space.
- R7: `stat` encodes AOK=1, HLT=2, ADR=3 and INS=4. A valid halt fetched from a good address gives HLT; every other valid instruction from a good address gives AOK.
- R8: INS is reported for opcodes 0xC..0xF. It is also reported when `ifun` is out of range: above 6 for 0x2 and 0x7, above 3 for 0x6, and non-zero for any other opcode. An undefined opcode is treated as one byte long, with `ra`=`rb`=0xF and `valc`=0.
- R9: When `addr_ok` is low, `stat` is ADR. This holds whatever the bytes are, and ADR takes priority over both INS and HLT.
- R10: Bytes of the window beyond the computed length have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc | input | 64 | Address of the instruction being fetched |
| win | input | 80 | Ten bytes of memory starting at `pc`, byte 0 in bits [7:0] |
| addr_ok | input | 1 | High when the fetch address is legal |
| icode | output | 4 | Instruction code |
| ifun | output | 4 | Function code |
| ra | output | 4 | First register specifier, 0xF when absent |
| rb | output | 4 | Second register specifier, 0xF when absent |
| valc | output | 64 | Little-endian constant, 0 when absent |
| valp | output | 64 | Next sequential PC |
| stat | output | 3 | Status: 1 AOK, 2 HLT, 3 ADR, 4 INS |

## Verification
The bench pushes every format through the block: short formats, register-byte formats, and nine- and ten-byte formats whose constants differ in every byte. A design that read the constant from the wrong offset, or in the wrong byte order, would return a shuffled `valc` for these. It also places a ten-byte instruction just below the top of the address space. A `valp` that saturated or grew wider than 64 bits would show up there.

Illegal function codes, undefined opcodes and a bad address combined with halt or with an undefined opcode probe the status priority. A design that let INS or HLT mask ADR would report the wrong code. Trailing junk after short and nine-byte instructions catches a decoder that lets bytes beyond the length leak into the fields.

// File: rtl/y86_fetch_decode.sv
module y86_fetch_decode #(
  parameter int ADDR_W = 64,
  parameter int WORD_W = 64
) (
  input  logic [ADDR_W-1:0]   pc,
  input  logic [WORD_W+15:0]  win,
  input  logic                addr_ok,
  output logic [3:0]          icode,
  output logic [3:0]          ifun,
  output logic [3:0]          ra,
  output logic [3:0]          rb,
  output logic [WORD_W-1:0]   valc,
  output logic [ADDR_W-1:0]   valp,
  output logic [2:0]          stat
);
  localparam logic [3:0] OP_HALT = 4'h0, OP_NOP = 4'h1, OP_RRMOV = 4'h2,
                         OP_IRMOV = 4'h3, OP_RMMOV = 4'h4, OP_MRMOV = 4'h5,
                         OP_ALU = 4'h6, OP_JMP = 4'h7, OP_CALL = 4'h8,
                         OP_RET = 4'h9, OP_PUSH = 4'hA, OP_POP = 4'hB;
  localparam logic [3:0] NO_REG = 4'hF;
  localparam logic [2:0] ST_AOK = 3'd1, ST_HLT = 3'd2, ST_ADR = 3'd3, ST_INS = 3'd4;

  logic       has_regs, has_const, legal;
  logic [3:0] len;

  assign icode = win[7:4];
  assign ifun  = win[3:0];

  always_comb begin
    has_regs  = 1'b0;
    has_const = 1'b0;
    legal     = 1'b1;
    unique case (icode)
      OP_HALT, OP_NOP, OP_RET:  legal = (ifun == 4'h0);
      OP_RRMOV: begin has_regs = 1'b1; legal = (ifun <= 4'h6); end
      OP_ALU:   begin has_regs = 1'b1; legal = (ifun <= 4'h3); end
      OP_PUSH, OP_POP: begin has_regs = 1'b1; legal = (ifun == 4'h0); end
      OP_JMP:   begin has_const = 1'b1; legal = (ifun <= 4'h6); end
      OP_CALL:  begin has_const = 1'b1; legal = (ifun == 4'h0); end
      OP_IRMOV, OP_RMMOV, OP_MRMOV: begin
        has_regs = 1'b1; has_const = 1'b1; legal = (ifun == 4'h0);
      end
      default:  legal = 1'b0;
    endcase
  end

  assign len  = 4'd1 + (has_regs ? 4'd1 : 4'd0) + (has_const ? 4'd8 : 4'd0);
  assign ra   = has_regs ? win[15:12] : NO_REG;
  assign rb   = has_regs ? win[11:8]  : NO_REG;
  assign valc = !has_const ? '0 : (has_regs ? win[WORD_W+15:16] : win[WORD_W+7:8]);
  assign valp = pc + ADDR_W'(len);

  always_comb begin
    if (!addr_ok)              stat = ST_ADR;
    else if (!legal)           stat = ST_INS;
    else if (icode == OP_HALT) stat = ST_HLT;
    else                       stat = ST_AOK;
  end
endmodule

// File: rtl/y86_fetch_decode_chk.sv
module y86_fetch_decode_chk #(
  parameter int ADDR_W = 64,
  parameter int WORD_W = 64
) (
  input logic [ADDR_W-1:0]  pc,
  input logic [WORD_W+15:0] win,
  input logic               addr_ok,
  input logic [3:0]         icode,
  input logic [3:0]         ra,
  input logic [3:0]         rb,
  input logic [WORD_W-1:0]  valc,
  input logic [ADDR_W-1:0]  valp,
  input logic [2:0]         stat
);
  logic [ADDR_W-1:0] step;
  logic              short_op;
  assign step     = valp - pc;
  assign short_op = (win[7:4] == 4'h0) || (win[7:4] == 4'h1) || (win[7:4] == 4'h9);

  always_comb begin
    if (!$isunknown({pc, win, addr_ok, icode, ra, rb, valc, valp, stat})) begin
      if (!addr_ok) AST_ADR_WINS: assert (stat == 3'd3);                       // R9
      if (addr_ok && win[7:0] == 8'h00) AST_HALT_STAT: assert (stat == 3'd2); // R7
      AST_STEP_LEGAL: assert (step == 1 || step == 2 || step == 9 || step == 10); // R6
      if (short_op) AST_SHORT_NOREG: assert (ra == 4'hF && rb == 4'hF && valc == '0); // R2
      AST_ICODE_NIBBLE: assert (icode == win[7:4]);                            // R1
    end
  end
endmodule

bind y86_fetch_decode y86_fetch_decode_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .pc(pc), .win(win), .addr_ok(addr_ok), .icode(icode), .ra(ra), .rb(rb),
  .valc(valc), .valp(valp), .stat(stat)
);

// File: tb/y86_fetch_decode_bench.sv
module y86_fetch_decode_bench;
  localparam int N = 22;

  localparam logic [79:0] V_WIN [0:N-1] = '{
    80'h10, 80'h90,                                  // R2
    80'h0000_0000_0000_0020_f530,                    // R5
    80'h0000_0000_0000_1234_7540,                    // R5
    80'h0000_0000_0000_0008_3450,                    // R5
    80'h1fb0, 80'h6fa0, 80'h4520,                    // R3
    80'h1226, 80'h1063,                              // R1
    80'h00_0123_4567_89ab_cdef_74,                   // R4
    80'h00_0000_0000_0000_0200_80,                   // R4
    80'h00,                                          // R7
    80'hc0, 80'h1267, 80'h11, 80'h1227,              // R8
    80'h10, 80'hf0,                                  // R9
    80'h0000_0000_0000_0020_f530,                    // R6
    80'hffff_ffff_ffff_ffff_ff10,                    // R10
    80'h00                                           // R9
  };
  localparam logic [63:0] V_PC [0:N-1] = '{
    64'h24, 64'h26, 64'h20, 64'h100, 64'ha0, 64'h22, 64'h30, 64'h40, 64'h0, 64'h50,
    64'h60, 64'h70, 64'h80, 64'h90, 64'h10, 64'h0, 64'h0, 64'h30, 64'h0,
    64'hffff_ffff_ffff_fffa, 64'h0, 64'h0
  };
  localparam logic V_OK [0:N-1] = '{1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,0,0,1,1,0};
  localparam int V_REQ [0:N-1] = '{2,2,5,5,5,3,3,3,1,1,4,4,7,8,8,8,8,9,9,6,10,9};
  localparam logic [3:0] E_IC [0:N-1] = '{1,9,3,4,5,11,10,2,2,6,7,8,0,12,6,1,2,1,15,3,1,0};
  localparam logic [3:0] E_IF [0:N-1] = '{0,0,0,0,0,0,0,0,6,3,4,0,0,0,7,1,7,0,0,0,0,0};
  localparam logic [3:0] E_RA [0:N-1] = '{15,15,15,7,3,1,6,4,1,1,15,15,15,15,1,15,1,15,15,15,15,15};
  localparam logic [3:0] E_RB [0:N-1] = '{15,15,5,5,4,15,15,5,2,0,15,15,15,15,2,15,2,15,15,5,15,15};
  localparam logic [63:0] E_VC [0:N-1] = '{
    64'h0, 64'h0, 64'd32, 64'h1234, 64'h8, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0,
    64'h0123_4567_89ab_cdef, 64'h200, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0,
    64'd32, 64'h0, 64'h0
  };
  localparam logic [63:0] E_VP [0:N-1] = '{
    64'h25, 64'h27, 64'h2a, 64'h10a, 64'haa, 64'h24, 64'h32, 64'h42, 64'h2, 64'h52,
    64'h69, 64'h79, 64'h81, 64'h91, 64'h12, 64'h1, 64'h2, 64'h31, 64'h1, 64'h4, 64'h1, 64'h1
  };
  localparam logic [2:0] E_ST [0:N-1] = '{1,1,1,1,1,1,1,1,1,1,1,1,2,4,4,4,4,3,3,1,1,3};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [63:0] pc;
  logic [79:0] win;
  logic        addr_ok;
  logic [3:0]  icode, ifun, ra, rb;
  logic [63:0] valc, valp;
  logic [2:0]  stat;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  y86_fetch_decode u_y86_fetch_decode (
    .pc(pc), .win(win), .addr_ok(addr_ok), .icode(icode), .ifun(ifun),
    .ra(ra), .rb(rb), .valc(valc), .valp(valp), .stat(stat)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [63:0] p, input logic [79:0] w, input logic ok);
    @(posedge clk);
    pc = p; win = w; addr_ok = ok;
    @(negedge clk);
  endtask

  initial begin
    pc = '0; win = '0; addr_ok = 1'b0;
    for (int i = 0; i < N; i++) begin
      string tag;
      apply(V_PC[i], V_WIN[i], V_OK[i]);
      tag = $sformatf("R%0d[v%0d]", V_REQ[i], i);
      chk(tag, "icode", 64'(icode), 64'(E_IC[i]));
      chk(tag, "ifun",  64'(ifun),  64'(E_IF[i]));
      chk(tag, "ra",    64'(ra),    64'(E_RA[i]));
      chk(tag, "rb",    64'(rb),    64'(E_RB[i]));
      chk(tag, "valc",  valc,       E_VC[i]);
      chk(tag, "valp",  valp,       E_VP[i]);
      chk(tag, "stat",  64'(stat),  64'(E_ST[i]));
    end
    // R10: a junk tenth byte after a nine-byte jump must not reach the outputs
    apply(64'h0, 80'hff_0000_0000_0000_0010_70, 1'b1);
    chk("R10", "valc", valc, 64'h10);
    chk("R10", "valp", valp, 64'h9);
    chk("R10", "ra",   64'(ra), 64'hf);
    // R9: the same bad opcode flips between INS and ADR with addr_ok alone
    apply(64'h8, 80'h1267, 1'b1);
    chk("R8", "stat", 64'(stat), 64'd4);
    apply(64'h8, 80'h1267, 1'b0);
    chk("R9", "stat", 64'(stat), 64'd3);
    // R6: a two-byte pop at the very last address wraps to 1
    apply(64'hffff_ffff_ffff_ffff, 80'h1fb0, 1'b1);
    chk("R6", "valp", valp, 64'h1);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule